// File: doc/BRIEF.md
# 16-bit Effective Offset Generator

This block turns the 16-bit addressing form of a ModRM byte into a 16-bit effective offset. A request is presented with a one-cycle `start` pulse that carries the ModRM byte, the four 16-bit pointer register values (BX, BP, SI, DI) and a segment-override code. The block then takes the displacement bytes the encoding calls for, 0, 1 or 2 of them, one per cycle when `byteValid` is high. It reports the result with a one-cycle `done` pulse.

With `done` the block presents the offset and the resolved segment code. It also flags an illegal register-direct encoding and a write through the code segment in flat mode, and gives the number of displacement bytes it took. Segment translation and SIB decoding belong to other blocks.

Segment codes on `segOverride` and `segOut`: 0 = default (no override), 1 = ES, 2 = CS, 3 = SS, 4 = DS, 5 = FS, 6 = GS.

Top module: `addr16_gen`

## Requirements
- R1: With mod 0 (r/m other than 6), the offset is the sum of a fixed register pair chosen by r/m (ModRM bits 2:0): 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. No displacement byte is taken.
- R2: With mod 1 (ModRM bits 7:6 = 01), one displacement byte is taken, sign-extended to 16 bits and added to the r/m register sum.
- R3: With mod 2, two displacement bytes are taken, low byte first, and the 16-bit value is added to the r/m register sum. Idle cycles with `byteValid` low may come between the bytes.
- R4: With mod 0 and r/m 6, the offset is the bare 16-bit displacement taken as two bytes, low byte first. No register is added and the default segment is not promoted to SS.
- R5: For r/m 2, 3 and 6 (except in the R4 case), a default segment code (0) resolves to SS (3). Every explicit override code, and the default code with any other r/m, is passed to `segOut` unchanged.
- R6: Mod 3 sets `invalid`, takes no displacement byte and gives an offset equal to the register sum alone.
- R7: All additions wrap modulo 2^16.
- R8: `done` is high for exactly one cycle. This is the cycle after the edge where `start` is taken when no byte is needed, or else the cycle after the edge where the last byte is taken. `bytesUsed` then equals the number of bytes taken.
- R9: `busy` is high from the cycle after an accepted start through the `done` cycle. A `start` while busy is ignored, and so is a `byteValid` while not waiting for a displacement byte.
- R10: `fault` is high with `done` when `flatMode` was high at start, ModRM bit 4 (write) was set and the override code was CS (2). Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| modrm | input | 8 | ModRM byte of the request |
| segOverride | input | 3 | Segment-override code, 0 = default |
| flatMode | input | 1 | Flat (non-segmented) addressing mode |
| regBx | input | 16 | BX value |
| regBp | input | 16 | BP value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| byteValid | input | 1 | Displacement byte present on byteData |
| byteData | input | 8 | Displacement byte stream |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| offset | output | 16 | Effective offset, valid with done |
| segOut | output | 3 | Resolved segment code, valid with done |
| invalid | output | 1 | Mod 3 encoding, valid with done |
| fault | output | 1 | Flat-mode write through CS, valid with done |
| bytesUsed | output | 2 | Displacement bytes taken, valid with done |

## Verification
Two pairs of events can land in the same cycle: a new `start` in the `done` cycle of the previous request, and a `byteValid` in the same cycle as the `start` that opens a request. The bench drives both. It raises `start` during `done` and checks that `busy` stays low afterwards. It also asserts `byteValid` with a junk byte alongside `start` and checks that the junk never reaches the offset or `bytesUsed`. A behavioural model in the bench predicts `done` and `busy` on every clock and predicts every result field at each `done`.

// File: rtl/addr16_pkg.sv
package addr16_pkg;

  localparam int SEG_W = 3;
  localparam logic [SEG_W-1:0] SEG_DEFAULT = 3'd0;
  localparam logic [SEG_W-1:0] SEG_CS      = 3'd2;
  localparam logic [SEG_W-1:0] SEG_SS      = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic takeLo;
    logic takeHi;
  } strobe_t;

  function automatic logic isDirect(input logic [1:0] modF, input logic [2:0] rmF);
    return (modF == 2'd0) && (rmF == 3'd6);
  endfunction

  function automatic logic [1:0] dispCount(input logic [1:0] modF, input logic [2:0] rmF);
    logic [1:0] n;
    case (modF)
      2'd1:    n = 2'd1;
      2'd2:    n = 2'd2;
      2'd0:    n = isDirect(modF, rmF) ? 2'd2 : 2'd0;
      default: n = 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/addr16_ctrl.sv
module addr16_ctrl
  import addr16_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] modField,
  input  logic [2:0] rmField,
  input  logic       byteValid,
  output strobe_t    stb,
  output logic       busy,
  output logic       done,
  output logic [1:0] usedCount
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FIN} state_e;

  state_e     state;
  logic [1:0] needQ;
  logic [1:0] usedQ;
  logic [1:0] needNow;

  assign needNow = dispCount(modField, rmField);

  always_comb begin
    stb.load   = (state == ST_IDLE) && start;
    stb.takeLo = (state == ST_FETCH) && byteValid && (usedQ == 2'd0);
    stb.takeHi = (state == ST_FETCH) && byteValid && (usedQ == 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      needQ <= 2'd0;
      usedQ <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            needQ <= needNow;
            usedQ <= 2'd0;
            state <= (needNow == 2'd0) ? ST_FIN : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (byteValid) begin
            usedQ <= usedQ + 2'd1;
            if ((usedQ + 2'd1) == needQ) state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign usedCount = usedQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8

  AST_LOAD_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> busy);  // R9

  AST_FETCH_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) |-> (usedQ < needQ));  // R3

endmodule

// File: rtl/addr16_dpath.sv
module addr16_dpath
  import addr16_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [1:0]        modField,
  input  logic [2:0]        rmField,
  input  logic              writeBit,
  input  logic [SEG_W-1:0]  segOverride,
  input  logic              flatMode,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  input  logic [7:0]        byteData,
  output logic [ADDR_W-1:0] offset,
  output logic [SEG_W-1:0]  segOut,
  output logic              invalid,
  output logic              fault
);

  localparam int HI_W = ADDR_W - 8;

  logic [1:0]        modQ;
  logic [2:0]        rmQ;
  logic              wrQ;
  logic              flatQ;
  logic [SEG_W-1:0]  segQ;
  logic [ADDR_W-1:0] baseQ;
  logic [7:0]        loQ;
  logic [7:0]        hiQ;
  logic [ADDR_W-1:0] baseNow;
  logic [ADDR_W-1:0] dispVal;
  logic              directQ;
  logic              bpForm;

  // register pair selected by r/m; zero for the bare displacement form
  always_comb begin
    case (rmField)
      3'd0: baseNow = regBx + regSi;
      3'd1: baseNow = regBx + regDi;
      3'd2: baseNow = regBp + regSi;
      3'd3: baseNow = regBp + regDi;
      3'd4: baseNow = regSi;
      3'd5: baseNow = regDi;
      3'd6: baseNow = regBp;
      default: baseNow = regBx;
    endcase
    if (isDirect(modField, rmField)) baseNow = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modQ  <= 2'd0;
      rmQ   <= 3'd0;
      wrQ   <= 1'b0;
      flatQ <= 1'b0;
      segQ  <= SEG_DEFAULT;
      baseQ <= '0;
      loQ   <= 8'd0;
      hiQ   <= 8'd0;
    end else begin
      if (stb.load) begin
        modQ  <= modField;
        rmQ   <= rmField;
        wrQ   <= writeBit;
        flatQ <= flatMode;
        segQ  <= segOverride;
        baseQ <= baseNow;
        loQ   <= 8'd0;
        hiQ   <= 8'd0;
      end
      if (stb.takeLo) loQ <= byteData;
      if (stb.takeHi) hiQ <= byteData;
    end
  end

  assign directQ = isDirect(modQ, rmQ);
  assign bpForm  = ((rmQ == 3'd2) || (rmQ == 3'd3) || (rmQ == 3'd6)) && !directQ;

  always_comb begin
    case (modQ)
      2'd1:    dispVal = {{HI_W{loQ[7]}}, loQ};
      2'd2:    dispVal = {{(HI_W-8){1'b0}}, hiQ, loQ};
      2'd0:    dispVal = directQ ? {{(HI_W-8){1'b0}}, hiQ, loQ} : '0;
      default: dispVal = '0;
    endcase
  end

  assign offset  = baseQ + dispVal;
  assign segOut  = ((segQ == SEG_DEFAULT) && bpForm) ? SEG_SS : segQ;
  assign invalid = (modQ == 2'd3);
  assign fault   = flatQ && wrQ && (segQ == SEG_CS);

  AST_KEEP_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (segQ != SEG_DEFAULT) |-> (segOut == segQ));  // R5

  AST_DIRECT_NO_PROMOTE: assert property (@(posedge clk) disable iff (!rstN)
    (directQ && (segQ == SEG_DEFAULT)) |-> (segOut == SEG_DEFAULT));  // R4

  AST_MOD3_NO_DISP: assert property (@(posedge clk) disable iff (!rstN)
    invalid |-> (offset == baseQ));  // R6

endmodule

// File: rtl/addr16_gen.sv
module addr16_gen
  import addr16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  modrm,
  input  logic [2:0]  segOverride,
  input  logic        flatMode,
  input  logic [15:0] regBx,
  input  logic [15:0] regBp,
  input  logic [15:0] regSi,
  input  logic [15:0] regDi,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        busy,
  output logic        done,
  output logic [15:0] offset,
  output logic [2:0]  segOut,
  output logic        invalid,
  output logic        fault,
  output logic [1:0]  bytesUsed
);

  localparam int ADDR_W = 16;

  strobe_t stb;
  logic    unusedRegOp;

  // bits 5 and 3 of the register/opcode field play no part in addressing
  assign unusedRegOp = modrm[5] ^ modrm[3];

  addr16_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modField  (modrm[7:6]),
    .rmField   (modrm[2:0]),
    .byteValid (byteValid),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .usedCount (bytesUsed)
  );

  addr16_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .modField    (modrm[7:6]),
    .rmField     (modrm[2:0]),
    .writeBit    (modrm[4]),
    .segOverride (segOverride),
    .flatMode    (flatMode),
    .regBx       (regBx),
    .regBp       (regBp),
    .regSi       (regSi),
    .regDi       (regDi),
    .byteData    (byteData),
    .offset      (offset),
    .segOut      (segOut),
    .invalid     (invalid),
    .fault       (fault)
  );

  AST_INVALID_NO_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (done && invalid) |-> (bytesUsed == 2'd0));  // R6

endmodule

// File: tb/addr16_gen_test.sv
module addr16_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  modrm = 8'd0;
  logic [2:0]  segOvr = 3'd0;
  logic        flatMode = 1'b0;
  logic [15:0] regBx = 16'd0, regBp = 16'd0, regSi = 16'd0, regDi = 16'd0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'd0;
  logic        busy, done, invalid, fault;
  logic [15:0] offset;
  logic [2:0]  segOut;
  logic [1:0]  bytesUsed;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  addr16_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .modrm(modrm), .segOverride(segOvr),
    .flatMode(flatMode), .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .byteValid(byteValid), .byteData(byteData), .busy(busy), .done(done),
    .offset(offset), .segOut(segOut), .invalid(invalid), .fault(fault),
    .bytesUsed(bytesUsed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int needOf(input logic [7:0] m);
    if (m[7:6] == 2'd1) return 1;
    if (m[7:6] == 2'd2) return 2;
    if (m[7:6] == 2'd0 && m[2:0] == 3'd6) return 2;
    return 0;
  endfunction

  // ---------------- behavioural reference model ----------------
  int mPhase = 0;  // 0 idle, 1 waiting bytes, 2 result cycle
  int mNeed, mGot;
  int mBytes[2];
  logic [7:0] mM;
  logic [2:0] mSeg;
  logic mFlat;
  int mBx, mBp, mSi, mDi;

  always @(posedge clk) begin
    if (!rstN) mPhase = 0;
    else begin
      case (mPhase)
        0: if (start) begin
             mM = modrm; mSeg = segOvr; mFlat = flatMode;
             mBx = regBx; mBp = regBp; mSi = regSi; mDi = regDi;
             mNeed = needOf(modrm); mGot = 0; mBytes[0] = 0; mBytes[1] = 0;
             mPhase = (mNeed == 0) ? 2 : 1;
           end
        1: if (byteValid) begin
             mBytes[mGot] = byteData; mGot++;
             if (mGot == mNeed) mPhase = 2;
           end
        default: mPhase = 0;
      endcase
    end
  end

  function automatic int expOffset();
    int base, disp;
    bit direct = (mM[7:6] == 0) && (mM[2:0] == 6);
    case (mM[2:0])
      0: base = mBx + mSi;
      1: base = mBx + mDi;
      2: base = mBp + mSi;
      3: base = mBp + mDi;
      4: base = mSi;
      5: base = mDi;
      6: base = mBp;
      default: base = mBx;
    endcase
    if (direct) base = 0;
    disp = 0;
    if (mM[7:6] == 1) disp = (mBytes[0] >= 128) ? mBytes[0] - 256 : mBytes[0];
    if (mM[7:6] == 2 || direct) disp = mBytes[0] + 256 * mBytes[1];
    return (base + disp) & 16'hFFFF;
  endfunction

  function automatic string offTag();
    if (mM[7:6] == 0 && mM[2:0] == 6) return "R4 offset";
    if (mM[7:6] == 1) return "R2 offset";
    if (mM[7:6] == 2) return "R3 offset";
    if (mM[7:6] == 3) return "R6 offset";
    return "R1 offset";
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(done == (mPhase == 2), "R8 done", done, mPhase == 2);
      chk(busy == (mPhase != 0), "R9 busy", busy, mPhase != 0);
      if (mPhase == 2) begin
        int eo, es;
        bit dir;
        eo = expOffset();
        dir = (mM[7:6] == 0) && (mM[2:0] == 6);
        es = mSeg;
        if (mSeg == 0 && !dir && (mM[2:0] == 2 || mM[2:0] == 3 || mM[2:0] == 6)) es = 3;
        chk(offset == eo[15:0], offTag(), offset, eo);
        chk(int'(segOut) == es, "R5 segOut", segOut, es);
        chk(invalid == (mM[7:6] == 3), "R6 invalid", invalid, mM[7:6] == 3);
        chk(fault == (mFlat && mM[4] && mSeg == 2), "R10 fault", fault, mFlat && mM[4] && mSeg == 2);
        chk(int'(bytesUsed) == mNeed, "R8 bytesUsed", bytesUsed, mNeed);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [7:0] m, input logic [2:0] seg, input logic flat,
                       input logic [7:0] b0, input logic [7:0] b1,
                       input int gap, input bit overlap);
    int n = needOf(m);
    @(negedge clk);
    modrm = m; segOvr = seg; flatMode = flat; start = 1'b1;
    if (overlap) begin byteValid = 1'b1; byteData = 8'hEE; end
    @(negedge clk);
    start = 1'b0; byteValid = 1'b0; modrm = 8'hC7; segOvr = 3'd5; flatMode = ~flat;
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(negedge clk);
      byteValid = 1'b1; byteData = (i == 0) ? b0 : b1;
      @(negedge clk);
      byteValid = 1'b0;
    end
    while (!done) @(negedge clk);
    if (overlap) begin start = 1'b1; modrm = 8'h00; end  // R9: start during done
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic setRegs(input logic [15:0] bx, bp, si, di);
    regBx = bx; regBp = bp; regSi = si; regDi = di;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 reset done", done, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 idle after reset", done, 0);

    // R1: all register pairs, mod 0, default segment (R5 promotion on 2,3,6)
    setRegs(16'h1000, 16'h2000, 16'h0030, 16'h0004);
    for (int r = 0; r < 8; r++) issue({2'b00, 3'b000, r[2:0]}, 3'd0, 1'b0, 8'h00, 8'h00, 0, 1'b0);

    // R4: bare displacement, low byte first, no SS promotion
    issue(8'h06, 3'd0, 1'b0, 8'h34, 8'h12, 0, 1'b0);
    issue(8'h06, 3'd4, 1'b0, 8'hCD, 8'hAB, 2, 1'b0);

    // R2: signed 8-bit displacement, positive and negative
    issue(8'h40, 3'd0, 1'b0, 8'h7F, 8'h00, 0, 1'b0);
    issue(8'h42, 3'd0, 1'b0, 8'h80, 8'h00, 1, 1'b0);
    issue(8'h47, 3'd0, 1'b0, 8'hFF, 8'h00, 0, 1'b0);

    // R3: 16-bit displacement with gaps
    issue(8'h83, 3'd0, 1'b0, 8'h34, 8'h12, 3, 1'b0);
    issue(8'h86, 3'd1, 1'b0, 8'h01, 8'h80, 0, 1'b0);

    // R7: wrap-around of register sum and displacement
    setRegs(16'hFFF0, 16'hFF00, 16'h0020, 16'hFFFF);
    issue(8'h00, 3'd0, 1'b0, 8'h00, 8'h00, 0, 1'b0);
    issue(8'h85, 3'd0, 1'b0, 8'h02, 8'h00, 0, 1'b0);
    issue(8'h43, 3'd0, 1'b0, 8'h80, 8'h00, 0, 1'b0);

    // R5: explicit override kept on BP forms; default kept on non-BP forms
    issue(8'h02, 3'd1, 1'b0, 8'h00, 8'h00, 0, 1'b0);
    issue(8'h46, 3'd4, 1'b0, 8'h10, 8'h00, 0, 1'b0);
    issue(8'h44, 3'd0, 1'b0, 8'h10, 8'h00, 0, 1'b0);

    // R6: register-direct encoding is invalid, no bytes
    issue(8'hC3, 3'd0, 1'b0, 8'h00, 8'h00, 0, 1'b0);

    // R10: flat-mode write through CS, and its near misses
    issue(8'h17, 3'd2, 1'b1, 8'h00, 8'h00, 0, 1'b0);
    issue(8'h07, 3'd2, 1'b1, 8'h00, 8'h00, 0, 1'b0);
    issue(8'h17, 3'd2, 1'b0, 8'h00, 8'h00, 0, 1'b0);
    issue(8'h57, 3'd4, 1'b1, 8'h05, 8'h00, 0, 1'b0);

    // R9: byte alongside start, start during done, stray byte while idle
    issue(8'h41, 3'd0, 1'b0, 8'h22, 8'h00, 0, 1'b1);
    issue(8'h06, 3'd0, 1'b0, 8'h78, 8'h56, 1, 1'b1);
    @(negedge clk);
    byteValid = 1'b1; byteData = 8'h99;
    @(negedge clk);
    byteValid = 1'b0;
    chk(done == 1'b0 && busy == 1'b0, "R9 idle byte ignored", busy, 0);
    issue(8'h40, 3'd0, 1'b0, 8'h03, 8'h00, 0, 1'b0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule